// File: doc/BRIEF.md
# Video Memory Decoder with Sprite Attribute RAM

This block sits between a CPU bus and the video hardware of a tile-and-sprite display. It splits the CPU address into eight 2 KB regions with a 3-to-8 decoder driven by address bits 13:11. It raises a select for the background character RAM, which is external. It also holds the sprite attribute RAM: 64 objects, each with a vertical-position byte, a horizontal-position byte and a sprite-code byte.

The attribute RAM has two users. The CPU writes and reads it through its window. The sprite renderer reads it through a second port, addressed by object index and field.

The RAM returns the bit-inverted value of what was stored. Its active-low chip enable comes from a two-input selector. With the render select low, the selector passes the CPU-side enable. With it high, the selector passes inputs tied to zero, so the RAM stays enabled for the whole sprite fetch.

Whenever the enable is inactive, the RAM drives nothing and its read data floats to all ones. A sprite fetch without the enable therefore yields code 0xFF instead of the stored code.

Top module: `vid_mem_decoder`

## Requirements
- R1: When `cpu_addr[15:14]` is 0, `blk_sel` is one-hot, with bit n high for `cpu_addr[13:11]` = n. Otherwise `blk_sel` is all zero.
- R2: `bg_cs` is high exactly for CPU addresses 0x3800–0x3FFF (decode value 7).
- R3: The attribute window is 0x3000–0x37FF (decode value 6). Byte offset `cpu_addr[7:0]` = 4*entry + field, where field 0 is vertical position, 1 is horizontal position and 2 is sprite code. Bits 10:8 are ignored, so each 256-byte block mirrors the same RAM.
- R4: A CPU write with `cpu_we` high in the attribute window takes effect at the clock edge. A following CPU read of that byte returns the bitwise complement of the written data.
- R5: While `rnd_sel` is high, `attr_ce_n` is low. `rnd_data` then returns the complement of the byte stored at entry `rnd_idx`, field `rnd_field`.
- R6: While `rnd_sel` is low, `attr_ce_n` is low only when the CPU address is in the attribute window.
- R7: With `attr_ce_n` high, both read outputs give 0xFF. `rnd_data` is 0xFF whenever `rnd_sel` is low. `cpu_rdata` is 0xFF outside the attribute window and whenever `rnd_sel` is high.
- R8: A CPU write while `rnd_sel` is high has no effect, because the render side has priority.
- R9: CPU writes outside the attribute window, or to field 3 of an entry, have no effect. Field 3 always reads 0xFF.
- R10: After reset, every attribute byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | CPU read data from the attribute RAM |
| blk_sel | output | 8 | One-hot decoder outputs |
| bg_cs | output | 1 | Background character RAM select |
| attr_ce_n | output | 1 | Attribute RAM chip enable, active low |
| rnd_sel | input | 1 | Render side owns the attribute RAM |
| rnd_idx | input | 6 | Render-side object index |
| rnd_field | input | 2 | Render-side field select |
| rnd_data | output | 8 | Render-side read data |

## Verification
The assertions check on every cycle that:
- the decoder never raises more than one select;
- the render select always forces the chip enable low;
- the enable follows the window decode when the render side is idle;
- a disabled RAM reads as all ones on both ports;
- a CPU write reads back inverted on the next cycle at the same address.

Only the bench scenarios can show the rest:
- writes made while the render side owns the RAM, or outside the window, leave the stored bytes unchanged;
- mirrored addresses reach the same byte;
- the render port sees the same data the CPU stored.

// File: rtl/vid_mem_decoder.sv
module vid_mem_decoder #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int NUM_OBJ = 64,
  parameter int NUM_FLD = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              cpu_addr,
  input  logic [DW-1:0]              cpu_wdata,
  input  logic                       cpu_we,
  output logic [DW-1:0]              cpu_rdata,
  output logic [7:0]                 blk_sel,
  output logic                       bg_cs,
  output logic                       attr_ce_n,
  input  logic                       rnd_sel,
  input  logic [$clog2(NUM_OBJ)-1:0] rnd_idx,
  input  logic [1:0]                 rnd_field,
  output logic [DW-1:0]              rnd_data
);
  localparam int IW = $clog2(NUM_OBJ);

  logic          dec_en;
  logic          cpu_ce_n;
  logic [IW-1:0] sel_idx;
  logic [1:0]    sel_fld;
  logic [DW-1:0] fld_q [NUM_FLD];
  logic [DW-1:0] raw_q;
  logic [DW-1:0] ram_q;
  logic          wr_ok;

  assign dec_en  = (cpu_addr[AW-1:14] == '0);
  assign blk_sel = dec_en ? (8'b1 << cpu_addr[13:11]) : 8'b0;
  assign bg_cs   = blk_sel[7];

  assign cpu_ce_n  = ~blk_sel[6];
  assign attr_ce_n = rnd_sel ? 1'b0 : cpu_ce_n;

  assign sel_idx = rnd_sel ? rnd_idx   : cpu_addr[IW+1:2];
  assign sel_fld = rnd_sel ? rnd_field : cpu_addr[1:0];

  assign wr_ok = cpu_we & ~rnd_sel & blk_sel[6];

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    logic [DW-1:0] mem [NUM_OBJ];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_OBJ; i++) mem[i] <= '0;
      end else if (wr_ok && cpu_addr[1:0] == 2'(f)) begin
        mem[cpu_addr[IW+1:2]] <= cpu_wdata;
      end
    end
    assign fld_q[f] = mem[sel_idx];
  end

  always_comb begin
    raw_q = '0;
    for (int f = 0; f < NUM_FLD; f++)
      if (sel_fld == 2'(f)) raw_q = fld_q[f];
  end

  assign ram_q     = attr_ce_n ? {DW{1'b1}} : ~raw_q;
  assign cpu_rdata = (!rnd_sel && blk_sel[6]) ? ram_q : {DW{1'b1}};
  assign rnd_data  = rnd_sel ? ram_q : {DW{1'b1}};
endmodule

// File: rtl/vid_mem_decoder_chk.sv
module vid_mem_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  blk_sel,
  input logic        attr_ce_n,
  input logic        rnd_sel,
  input logic [7:0]  rnd_data
);
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(blk_sel)); // R1
  AST_CE_FORCED: assert property (@(posedge clk) disable iff (!rst_n) rnd_sel |-> !attr_ce_n); // R5
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!rnd_sel && !blk_sel[6]) |-> attr_ce_n); // R6
  AST_OFF_ONES: assert property (@(posedge clk) disable iff (!rst_n) attr_ce_n |-> (cpu_rdata == 8'hFF && rnd_data == 8'hFF)); // R7
  AST_WR_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && blk_sel[6] && !rnd_sel && cpu_addr[1:0] != 2'd3) |=>
    (!$stable(cpu_addr) || rnd_sel || cpu_rdata == ~$past(cpu_wdata))); // R4
endmodule

bind vid_mem_decoder vid_mem_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .blk_sel(blk_sel),
  .attr_ce_n(attr_ce_n), .rnd_sel(rnd_sel), .rnd_data(rnd_data)
);

// File: tb/test_vid_mem_decoder.sv
module test_vid_mem_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 0;
  logic [7:0]  cpu_rdata;
  logic [7:0]  blk_sel;
  logic        bg_cs;
  logic        attr_ce_n;
  logic        rnd_sel = 0;
  logic [5:0]  rnd_idx = '0;
  logic [1:0]  rnd_field = '0;
  logic [7:0]  rnd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vid_mem_decoder i_vid_mem_decoder (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] attr_a(input int idx, input int fld, input int mir);
    return 16'h3000 + 16'(mir * 256) + 16'(idx * 4 + fld);
  endfunction

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic cpu_rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; #1;
    chk(tag, {8'h0, cpu_rdata}, {8'h0, exp});
  endtask

  task automatic rnd_rd(input string tag, input int idx, input int fld, input logic [7:0] exp);
    @(negedge clk);
    rnd_sel = 1; rnd_idx = 6'(idx); rnd_field = 2'(fld); #1;
    chk({tag, " ce"}, {15'h0, attr_ce_n}, 16'h0);
    chk(tag, {8'h0, rnd_data}, {8'h0, exp});
    rnd_sel = 0; #1;
    chk({tag, " idle"}, {8'h0, rnd_data}, 16'h00FF);
  endtask

  task automatic t_reset;
    cpu_rd("R10 reset v", attr_a(0, 0, 0), 8'hFF);
    cpu_rd("R10 reset c", attr_a(63, 2, 0), 8'hFF);
  endtask

  task automatic t_decode;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      cpu_addr = 16'(n * 16'h0800) + 16'h0123; #1;
      chk("R1 decode", {8'h0, blk_sel}, {8'h0, 8'(1 << n)});
      chk("R2 bg_cs", {15'h0, bg_cs}, {15'h0, n == 7});
      chk("R6 ce", {15'h0, attr_ce_n}, {15'h0, n != 6});
    end
    @(negedge clk);
    cpu_addr = 16'hB800; #1;
    chk("R1 high bits", {8'h0, blk_sel}, 16'h0);
    chk("R2 high bits", {15'h0, bg_cs}, 16'h0);
    chk("R7 outside", {8'h0, cpu_rdata}, 16'h00FF);
  endtask

  task automatic t_write_read;
    cpu_wr(attr_a(0, 0, 0), 8'hB4);
    cpu_wr(attr_a(0, 1, 0), 8'h4B);
    cpu_wr(attr_a(0, 2, 0), 8'h28);
    cpu_wr(attr_a(63, 2, 0), 8'h00);
    cpu_rd("R4 vert", attr_a(0, 0, 0), 8'h4B);
    cpu_rd("R4 horiz", attr_a(0, 1, 0), 8'hB4);
    cpu_rd("R4 code", attr_a(0, 2, 0), 8'hD7);
    cpu_rd("R4 last entry", attr_a(63, 2, 0), 8'hFF);
    cpu_rd("R3 mirror", attr_a(0, 2, 5), 8'hD7);
  endtask

  task automatic t_render;
    rnd_rd("R5 code", 0, 2, 8'hD7);
    rnd_rd("R5 vert", 0, 0, 8'h4B);
    rnd_rd("R9 field3", 0, 3, 8'hFF);
    @(negedge clk);
    cpu_addr = 16'h0000; #1;
    chk("R7 disabled", {8'h0, rnd_data}, 16'h00FF);
  endtask

  task automatic t_priority;
    @(negedge clk);
    rnd_sel = 1; rnd_idx = 6'd0; rnd_field = 2'd2;
    cpu_addr = attr_a(0, 2, 0); cpu_wdata = 8'h55; cpu_we = 1; #1;
    chk("R7 cpu blocked", {8'h0, cpu_rdata}, 16'h00FF);
    @(negedge clk);
    cpu_we = 0; rnd_sel = 0;
    cpu_rd("R8 no write", attr_a(0, 2, 0), 8'hD7);
  endtask

  task automatic t_ignored;
    cpu_wr(16'h3803, 8'h11);
    cpu_wr(16'h7004, 8'h22);
    cpu_wr(attr_a(1, 3, 0), 8'h33);
    cpu_rd("R9 bg write", attr_a(0, 3, 0), 8'hFF);
    cpu_rd("R9 high write", attr_a(1, 0, 0), 8'hFF);
    cpu_rd("R9 field3 write", attr_a(1, 3, 0), 8'hFF);
    cpu_wr(attr_a(1, 0, 7), 8'h0F);
    cpu_rd("R3 mirror write", attr_a(1, 0, 0), 8'hF0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_decode;
        t_write_read;
        t_render;
        t_priority;
        t_ignored;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule